// File: doc/BRIEF.md
# Receive-Only Byte Request Engine

This block runs receive-only transfers for a serial host controller, where no transmit data exists. Software writes a byte count into a request input. The block then keeps the shift engine clocked until that many bytes have arrived. The configured word length plays no part here: incoming bytes are always packed into 32-bit words before they are pushed to the receive FIFO.

A 16-bit to-do counter shows how many bytes are still owed. When the transfer ends with one to three bytes of an unfinished word, that word is pushed at once. It is right-aligned, with the oldest byte in the most significant valid byte lane. A 3-bit byte-valid field tells the reader how many lanes of that last word hold data. Software caps each request at four times the receive FIFO depth, and the block accepts every count up to that cap.

Top module: `rxo_request_engine`

## Requirements
- R1: After reset, todo_count is 0, shift_en is 0, push_valid is 0 and byte_valid is 0.
- R2: A request write loads req_count into todo_count on the next clock edge. shift_en is 1 in exactly those cycles in which todo_count is nonzero.
- R3: Each byte strobe taken while todo_count is nonzero lowers todo_count by one. A strobe while todo_count is zero changes nothing and pushes nothing.
- R4: Four taken bytes form one 32-bit word. The first byte received goes in bits 31:24 and the fourth in bits 7:0. The word is pushed (push_valid high for one cycle) in the cycle after the fourth strobe, and byte_valid then reads 0, meaning all four lanes.
- R5: If todo_count reaches zero with 1 to 3 bytes gathered, the word is pushed in the next cycle. It is right-aligned: the earliest byte is in the most significant valid lane, and unused upper lanes are zero. byte_valid gives the count, 1 to 3, and keeps that value until the next push or request.
- R6: A request written while todo_count is nonzero replaces the remaining count, and any bytes gathered for the unfinished word are dropped.
- R7: A request of zero leaves shift_en low and pushes nothing.
- R8: When a request write and a byte strobe fall in the same cycle, the request wins and the byte is dropped.
- R9: Any count up to 4 × FIFO_DEPTH (32 by default) is accepted, giving count/4 full words in arrival order followed by at most one partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_we | input | 1 | Request write strobe |
| req_count | input | 16 | Byte count to receive |
| rx_byte_stb | input | 1 | A byte has arrived from the shift engine |
| rx_byte | input | 8 | The byte that arrived |
| shift_en | output | 1 | Clock enable for the shift engine |
| todo_count | output | 16 | Bytes still to be received |
| byte_valid | output | 3 | Valid lanes of the last pushed word (0 = all four) |
| push_valid | output | 1 | Receive FIFO push strobe |
| push_data | output | 32 | Packed word for the FIFO |

## Verification
A request write shows up in todo_count and shift_en one edge later. A taken byte changes todo_count one edge later, and when it completes a word it also raises push_valid, push_data and byte_valid on that same edge. The bench drives every input on the falling edge and holds it through exactly one rising edge. It then reads the outputs on the next falling edge, so each result is checked in the single cycle in which it is due. After that sample, idle cycles confirm that push_valid lasts only one cycle and that byte_valid holds its value.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned WORD_LANES = 4;
   localparam int unsigned WORD_W    = BYTE_W * WORD_LANES;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rxo_todo_counter.sv
module rxo_todo_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             take,
   output logic [CNT_W-1:0] remain,
   output logic             active,
   output logic             last
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (load) begin
         remain <= load_val;
      end else if (take) begin
         remain <= remain - ONE;
      end
   end

   assign active = |remain;
   assign last   = (remain == ONE);
endmodule

// File: rtl/rxo_packer.sv
module rxo_packer #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned BYTE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear,
   input  logic                      take,
   input  logic                      last,
   input  logic [BYTE_W-1:0]         in_byte,
   output logic                      push_valid,
   output logic [LANES*BYTE_W-1:0]   push_data,
   output logic [$clog2(LANES):0]    byte_valid
);
   localparam int unsigned FILL_W = $clog2(LANES);
   localparam int unsigned BV_W   = FILL_W + 1;
   localparam int unsigned WORD_W = LANES * BYTE_W;
   localparam logic [FILL_W-1:0] FULL_AT = FILL_W'(LANES - 1);

   logic [FILL_W-1:0] fill_q;
   logic [BYTE_W-1:0] lane_q [LANES-1];
   logic [WORD_W-1:0] word_now;
   logic              word_done;

   assign word_done = take && ((fill_q == FULL_AT) || last);
   assign word_now[BYTE_W-1:0] = in_byte;

   // Lane i holds the byte received i+1 strobes ago within the current word.
   for (genvar i = 0; i < LANES - 1; i++) begin : g_lane
      assign word_now[(i+1)*BYTE_W +: BYTE_W] = lane_q[i];
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 lane_q[i] <= '0;
            else if (clear || word_done) lane_q[i] <= '0;
            else if (take)              lane_q[i] <= in_byte;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 lane_q[i] <= '0;
            else if (clear || word_done) lane_q[i] <= '0;
            else if (take)              lane_q[i] <= lane_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q     <= '0;
         push_valid <= 1'b0;
         push_data  <= '0;
         byte_valid <= '0;
      end else begin
         push_valid <= 1'b0;
         if (clear) begin
            fill_q     <= '0;
            byte_valid <= '0;
         end else if (word_done) begin
            fill_q     <= '0;
            push_valid <= 1'b1;
            push_data  <= word_now;
            byte_valid <= (fill_q == FULL_AT) ? '0 : (BV_W'(fill_q) + BV_W'(1));
         end else if (take) begin
            fill_q <= fill_q + FILL_W'(1);
         end
      end
   end
endmodule

// File: rtl/rxo_request_engine.sv
module rxo_request_engine #(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned FIFO_DEPTH = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             req_we,
   input  logic [CNT_W-1:0]                 req_count,
   input  logic                             rx_byte_stb,
   input  logic [rxo_pkg::BYTE_W-1:0]       rx_byte,
   output logic                             shift_en,
   output logic [CNT_W-1:0]                 todo_count,
   output logic [$clog2(rxo_pkg::WORD_LANES):0] byte_valid,
   output logic                             push_valid,
   output logic [rxo_pkg::WORD_W-1:0]       push_data
);
   localparam int unsigned LANES   = rxo_pkg::WORD_LANES;
   localparam longint      MAX_REQ = longint'(LANES) * longint'(FIFO_DEPTH);

   if (LANES < 2) begin : g_bad_lanes
      $error("rxo_request_engine: at least two byte lanes are needed");
   end
   if (MAX_REQ > ((longint'(1) << CNT_W) - 1)) begin : g_bad_cnt
      $error("rxo_request_engine: counter too narrow for the largest request");
   end
   if (FIFO_DEPTH < 1) begin : g_bad_depth
      $error("rxo_request_engine: FIFO_DEPTH must be nonzero");
   end

   logic active, last, take;

   // A request in the same cycle as a strobe wins; the byte is dropped.
   assign take     = rx_byte_stb && active && !req_we;
   assign shift_en = active;

   rxo_todo_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (req_we),
      .load_val (req_count),
      .take     (take),
      .remain   (todo_count),
      .active   (active),
      .last     (last)
   );

   rxo_packer #(.LANES(LANES), .BYTE_W(rxo_pkg::BYTE_W)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (req_we),
      .take       (take),
      .last       (last),
      .in_byte    (rx_byte),
      .push_valid (push_valid),
      .push_data  (push_data),
      .byte_valid (byte_valid)
   );
endmodule

// File: rtl/rxo_request_checker.sv
module rxo_request_checker #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned BV_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_we,
   input logic [CNT_W-1:0] req_count,
   input logic             rx_byte_stb,
   input logic             shift_en,
   input logic [CNT_W-1:0] todo_count,
   input logic [BV_W-1:0]  byte_valid,
   input logic             push_valid
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_we |=> todo_count == $past(req_count));

   p_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_we |=> todo_count <= $past(todo_count));

   p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_byte_stb && shift_en && !req_we) |=> todo_count == $past(todo_count) - ONE);

   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_we && todo_count == '0) |=> (todo_count == '0 && !push_valid));

   p_last_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_byte_stb && !req_we && todo_count == ONE) |=> push_valid);

   p_partial_only_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && byte_valid != '0) |-> todo_count == '0);

   p_zero_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_we && req_count == '0) |=> (!shift_en && !push_valid));

   p_req_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_we |=> !push_valid);
endmodule

bind rxo_request_engine rxo_request_checker #(
   .CNT_W (CNT_W),
   .BV_W  ($clog2(rxo_pkg::WORD_LANES) + 1)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_we      (req_we),
   .req_count   (req_count),
   .rx_byte_stb (rx_byte_stb),
   .shift_en    (shift_en),
   .todo_count  (todo_count),
   .byte_valid  (byte_valid),
   .push_valid  (push_valid)
);

// File: tb/sim_rxo_request_engine.sv
module sim_rxo_request_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_we = 1'b0;
   logic [15:0] req_count = '0;
   logic        rx_byte_stb = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        shift_en;
   logic [15:0] todo_count;
   logic [2:0]  byte_valid;
   logic        push_valid;
   logic [31:0] push_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   rxo_request_engine u0 (
      .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_count(req_count),
      .rx_byte_stb(rx_byte_stb), .rx_byte(rx_byte), .shift_en(shift_en),
      .todo_count(todo_count), .byte_valid(byte_valid),
      .push_valid(push_valid), .push_data(push_data)
   );

   // {count[15:0], seed[7:0]}; count 32 is the 4 x FIFO_DEPTH ceiling.
   localparam logic [23:0] VEC [8] = '{
      {16'd1,  8'h11}, {16'd2,  8'h22}, {16'd3,  8'h33}, {16'd4,  8'h44},
      {16'd5,  8'h55}, {16'd6,  8'h66}, {16'd9,  8'h77}, {16'd32, 8'h80}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic request(input logic [15:0] n);
      @(negedge clk);
      req_we = 1'b1; req_count = n;
      @(negedge clk);
      req_we = 1'b0;
   endtask

   task automatic strobe(input logic [7:0] b);
      @(negedge clk);
      rx_byte_stb = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_byte_stb = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] w;
      logic [15:0] n;
      logic [7:0]  b;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 todo", 32'(todo_count), 0);
      chk("R1 shift_en", 32'(shift_en), 0);
      chk("R1 push", 32'(push_valid), 0);
      chk("R1 byte_valid", 32'(byte_valid), 0);
      rst_n = 1'b1;
      idle();

      // Table walk: R2, R3, R4, R5, R9
      for (int v = 0; v < 8; v++) begin
         n = VEC[v][23:8];
         request(n);
         chk("R2 todo load", 32'(todo_count), 32'(n));
         chk("R2 shift_en on", 32'(shift_en), 1);
         w = '0;
         for (int i = 0; i < int'(n); i++) begin
            b = VEC[v][7:0] ^ 8'(i * 37);
            w = (i % 4 == 0) ? 32'(b) : {w[23:0], b};
            strobe(b);
            chk("R3 todo dec", 32'(todo_count), 32'(int'(n) - i - 1));
            if (i % 4 == 3) begin
               chk("R4 push full", 32'(push_valid), 1);
               chk("R4 word", push_data, w);
               chk("R4 bv zero", 32'(byte_valid), 0);
            end else if (i == int'(n) - 1) begin
               chk("R5 push partial", 32'(push_valid), 1);
               chk("R5 word", push_data, w);
               chk("R5 bv", 32'(byte_valid), 32'(i % 4 + 1));
            end else begin
               chk("R4 no early push", 32'(push_valid), 0);
            end
            if (i % 3 == 2) begin
               idle();
               chk("R4 push one cycle", 32'(push_valid), 0);
            end
         end
         chk("R2 shift_en off", 32'(shift_en), 0);
      end

      // R5 byte_valid held; R3 strobe while idle ignored
      request(16'd2);
      strobe(8'hA1); strobe(8'hA2);
      chk("R5 two-byte word", push_data, 32'h0000A1A2);
      idle(); idle();
      chk("R5 bv held", 32'(byte_valid), 2);
      strobe(8'hEE);
      chk("R3 idle todo", 32'(todo_count), 0);
      chk("R3 idle push", 32'(push_valid), 0);
      chk("R3 idle data", push_data, 32'h0000A1A2);

      // R7 zero request
      request(16'd0);
      chk("R7 shift_en", 32'(shift_en), 0);
      chk("R7 push", 32'(push_valid), 0);
      chk("R7 todo", 32'(todo_count), 0);

      // R6 replace mid-request drops gathered bytes
      request(16'd6);
      strobe(8'hB1); strobe(8'hB2);
      request(16'd3);
      chk("R6 todo replaced", 32'(todo_count), 3);
      chk("R6 bv cleared", 32'(byte_valid), 0);
      strobe(8'hC1); strobe(8'hC2); strobe(8'hC3);
      chk("R6 push", 32'(push_valid), 1);
      chk("R6 word", push_data, 32'h00C1C2C3);
      chk("R6 bv", 32'(byte_valid), 3);

      // R8 request and strobe in the same cycle
      request(16'd4);
      strobe(8'hD1);
      @(negedge clk);
      req_we = 1'b1; req_count = 16'd2; rx_byte_stb = 1'b1; rx_byte = 8'hDD;
      @(negedge clk);
      req_we = 1'b0; rx_byte_stb = 1'b0;
      chk("R8 todo", 32'(todo_count), 2);
      chk("R8 no push", 32'(push_valid), 0);
      strobe(8'hE1); strobe(8'hE2);
      chk("R8 word", push_data, 32'h0000E1E2);
      chk("R8 bv", 32'(byte_valid), 2);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule